// File: doc/BRIEF.md
# Dual-Clock Compare Timer for Wake-Up

This block is a free-running up-counter meant to wake a system from a low-power state. Software reaches it through a small word-addressed register port clocked by a fast bus clock. The counter itself lives in a separate, slow engine clock domain, so it keeps counting when the bus clock is gated. A prescaler slows the count. A compare value sets the match point, and every match raises an interrupt flag and a wake-up flag. Each flag drives its own output through its own enable.

Software first programs the prescaler and the compare value, then sets the run bit. It polls the active bit until the engine has really started. From then on it can move the compare point at any time without disturbing the count, and it clears flags by writing ones to the status register. Configuration crosses to the engine through a toggle-and-capture scheme. The counter comes back to the bus side through a closed request/acknowledge loop, so a read never returns a torn value. Software must leave a few engine clocks between configuration writes.

Register map (word address): 0 = control, 1 = compare, 2 = status, 3 = counter. Control bit 0 is run, bit 1 is the interrupt enable, bit 2 is the wake enable and bit 3 is the counter-read enable. Bits 8 and up (PSC_W bits) hold the prescaler, and bit 31 is the read-only active bit. Status bit 0 is the interrupt flag and bit 1 is the wake flag.

Top module: `lptmr_top`

## Requirements
- R1: The counter is CNT_W bits wide. It steps by one on each prescaled engine tick while running, and it wraps from all ones to zero.
- R2: With prescaler field p (control bits starting at bit 8, range 0 to 2^PSC_W-1), the counter advances once every p+1 engine clocks. Changing p while running does not reset the counter.
- R3: When the counter steps onto the effective compare value, both status flags are set (bit 0 interrupt, bit 1 wake). The counter keeps counting and is neither reset nor stopped.
- R4: Writing the compare register (address 1) while running leaves the counter value untouched. The new value becomes the match point.
- R5: Clearing run holds the counter at its value. Setting run again from stopped restarts the counter from zero.
- R6: A compare value below 2 acts as 2. With compare 1, no match occurs while the counter reads 1.
- R7: A read of control or compare returns the bus-side copy, starting on the cycle after the write. The compare copy keeps only the low CNT_W bits of the write data. The engine applies a write within SYNC_N+2 engine clock edges.
- R8: Writing 1 to status bit 0 clears the interrupt flag, and writing 1 to bit 1 clears the wake flag. A zero bit leaves its flag as it is, and one write can clear both.
- R9: Control bit 31 reads 1 only once the engine domain is counting. It is still 0 on the bus cycle right after the run write, and it returns to 0 after a stop.
- R10: Address 3 returns a coherent recent counter value when control bit 3 is set. It returns 0 when control bit 3 is clear.
- R11: Output irq is a registered copy of (interrupt flag AND control bit 1). Output wake is a registered copy of (wake flag AND control bit 2). Both are 0 out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Fast register-side clock |
| eng_clk | input | 1 | Slow counting-engine clock, asynchronous to bus_clk |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Register write strobe, sampled on bus_clk |
| addr | input | 2 | Word address of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Registered match interrupt request |
| wake | output | 1 | Registered wake-up request |

## Verification
The bench builds the timer with CNT_W = 10, keeping the default 7-bit prescaler and two-stage synchronizers. The narrow counter brings the wrap from all ones to zero within a few hundred microseconds of engine time, and matches that occur just after a wrap also come within reach. Keeping the full prescaler width allows the largest divide of 128. That spreads ticks far enough apart to show that a compare value of 1 is treated as 2, because the counter can be caught reading 1 with no flag set. The engine clock runs at a ratio to the 250 MHz bus clock that is not an integer, so the crossings are exercised at phases that keep shifting.

// File: rtl/lptmr_pkg.sv
`timescale 1ns/1ps
package lptmr_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL = 2'd0,
      REG_CMP  = 2'd1,
      REG_STAT = 2'd2,
      REG_CNT  = 2'd3
   } reg_e;

   // control bit positions
   localparam int B_RUN  = 0;
   localparam int B_IE   = 1;
   localparam int B_WE   = 2;
   localparam int B_RDEN = 3;
   localparam int B_PSC  = 8;
   localparam int B_ACT  = 31;

   // status bit positions
   localparam int B_IF = 0;
   localparam int B_WF = 1;
endpackage

// File: rtl/lptmr_sync.sv
`timescale 1ns/1ps
module lptmr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else        r <= {r[STAGES-2:0], d};
   end

   assign q = r[STAGES-1];
endmodule

// File: rtl/lptmr_engine.sv
`timescale 1ns/1ps
module lptmr_engine #(
   parameter int CNT_W   = 24,
   parameter int PSC_W   = 7,
   parameter int SYNC_N  = 2,
   parameter bit HAS_PSC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_tgl,
   input  logic             cfg_run,
   input  logic [PSC_W-1:0] cfg_psc,
   input  logic [CNT_W-1:0] cfg_cmp,
   input  logic             snap_req,
   output logic             match_tgl,
   output logic             active,
   output logic             snap_ack,
   output logic [CNT_W-1:0] snap_val,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CMP_MIN = CNT_W'(2);

   logic             cfg_s, cfg_seen, load, start;
   logic             req_s, req_seen;
   logic             run_e, tick;
   logic [PSC_W-1:0] psc_e;
   logic [CNT_W-1:0] cmp_e, eff_cmp, cnt, cnt_nx;

   lptmr_sync #(.STAGES(SYNC_N)) u_cfg_sync (.clk(clk), .rst_n(rst_n), .d(cfg_tgl),  .q(cfg_s));
   lptmr_sync #(.STAGES(SYNC_N)) u_req_sync (.clk(clk), .rst_n(rst_n), .d(snap_req), .q(req_s));

   assign load    = cfg_s ^ cfg_seen;
   assign start   = load & cfg_run & ~run_e;
   assign eff_cmp = (cmp_e < CMP_MIN) ? CMP_MIN : cmp_e;
   assign cnt_nx  = (cnt == CNT_MAX) ? '0 : cnt + 1'b1;

   // capture of the bus-side configuration once the toggle has settled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_seen <= 1'b0;
         run_e    <= 1'b0;
         psc_e    <= '0;
         cmp_e    <= '0;
      end else begin
         cfg_seen <= cfg_s;
         if (load) begin
            run_e <= cfg_run;
            psc_e <= cfg_psc;
            cmp_e <= cfg_cmp;
         end
      end
   end

   generate
      if (HAS_PSC) begin : g_psc
         logic [PSC_W-1:0] pc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     pc <= '0;
            else if (!run_e || pc >= psc_e) pc <= '0;
            else                            pc <= pc + 1'b1;
         end
         assign tick = run_e && (pc >= psc_e);
      end else begin : g_nopsc
         logic unused_psc;
         assign unused_psc = ^psc_e;
         assign tick = run_e;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         match_tgl <= 1'b0;
      end else if (start) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= cnt_nx;
         if (cnt_nx == eff_cmp) match_tgl <= ~match_tgl;
      end
   end

   // snapshot loop: hold stays put until the bus side asks again
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_seen <= 1'b0;
         snap_ack <= 1'b0;
         snap_val <= '0;
      end else begin
         req_seen <= req_s;
         if (req_s ^ req_seen) begin
            snap_val <= cnt;
            snap_ack <= ~snap_ack;
         end
      end
   end

   assign active = run_e;
   assign cnt_o  = cnt;
endmodule

// File: rtl/lptmr_regs.sv
`timescale 1ns/1ps
module lptmr_regs
   import lptmr_pkg::*;
#(
   parameter int CNT_W  = 24,
   parameter int PSC_W  = 7,
   parameter int SYNC_N = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              cfg_tgl,
   output logic              cfg_run,
   output logic [PSC_W-1:0]  cfg_psc,
   output logic [CNT_W-1:0]  cfg_cmp,
   input  logic              match_tgl,
   input  logic              eng_active,
   output logic              snap_req,
   input  logic              snap_ack,
   input  logic [CNT_W-1:0]  snap_val,
   output logic              int_flag,
   output logic              wake_flag,
   output logic              irq,
   output logic              wake
);
   logic             ie, we, rden;
   logic             match_s, match_seen, act_s, ack_s, ack_seen;
   logic             wr_ctrl, wr_cmp, wr_stat, match_evt;
   logic [CNT_W-1:0] cnt_q;
   logic             unused_wbits;

   lptmr_sync #(.STAGES(SYNC_N)) u_match_sync (.clk(clk), .rst_n(rst_n), .d(match_tgl),  .q(match_s));
   lptmr_sync #(.STAGES(SYNC_N)) u_act_sync   (.clk(clk), .rst_n(rst_n), .d(eng_active), .q(act_s));
   lptmr_sync #(.STAGES(SYNC_N)) u_ack_sync   (.clk(clk), .rst_n(rst_n), .d(snap_ack),   .q(ack_s));

   assign wr_ctrl      = wr_en && (addr == REG_CTRL);
   assign wr_cmp       = wr_en && (addr == REG_CMP);
   assign wr_stat      = wr_en && (addr == REG_STAT);
   assign match_evt    = match_s ^ match_seen;
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_tgl    <= 1'b0;
         cfg_run    <= 1'b0;
         cfg_psc    <= '0;
         cfg_cmp    <= '0;
         ie         <= 1'b0;
         we         <= 1'b0;
         rden       <= 1'b0;
         match_seen <= 1'b0;
         ack_seen   <= 1'b0;
         snap_req   <= 1'b1;
         cnt_q      <= '0;
         int_flag   <= 1'b0;
         wake_flag  <= 1'b0;
         irq        <= 1'b0;
         wake       <= 1'b0;
      end else begin
         match_seen <= match_s;
         ack_seen   <= ack_s;
         if (wr_ctrl) begin
            cfg_run <= wdata[B_RUN];
            ie      <= wdata[B_IE];
            we      <= wdata[B_WE];
            rden    <= wdata[B_RDEN];
            cfg_psc <= wdata[B_PSC +: PSC_W];
         end
         if (wr_cmp) cfg_cmp <= wdata[CNT_W-1:0];
         if (wr_ctrl || wr_cmp) cfg_tgl <= ~cfg_tgl;
         int_flag  <= match_evt | (int_flag  & ~(wr_stat & wdata[B_IF]));
         wake_flag <= match_evt | (wake_flag & ~(wr_stat & wdata[B_WF]));
         irq  <= int_flag  & ie;
         wake <= wake_flag & we;
         if (ack_s ^ ack_seen) begin
            cnt_q    <= snap_val;
            snap_req <= ~snap_req;
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         REG_CTRL: begin
            rdata[B_RUN]          = cfg_run;
            rdata[B_IE]           = ie;
            rdata[B_WE]           = we;
            rdata[B_RDEN]         = rden;
            rdata[B_PSC +: PSC_W] = cfg_psc;
            rdata[B_ACT]          = act_s;
         end
         REG_CMP:  rdata[CNT_W-1:0] = cfg_cmp;
         REG_STAT: begin
            rdata[B_IF] = int_flag;
            rdata[B_WF] = wake_flag;
         end
         REG_CNT:  if (rden) rdata[CNT_W-1:0] = cnt_q;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/lptmr_top.sv
`timescale 1ns/1ps
module lptmr_top
   import lptmr_pkg::*;
#(
   parameter int CNT_W   = 24,
   parameter int PSC_W   = 7,
   parameter int SYNC_N  = 2,
   parameter bit HAS_PSC = 1'b1
) (
   input  logic              bus_clk,
   input  logic              eng_clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              irq,
   output logic              wake
);
   logic             cfg_tgl, cfg_run, match_tgl, eng_active;
   logic             snap_req, snap_ack, int_flag, wake_flag;
   logic [PSC_W-1:0] cfg_psc;
   logic [CNT_W-1:0] cfg_cmp, snap_val, eng_cnt;

   lptmr_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .SYNC_N(SYNC_N)) u_regs (
      .clk(bus_clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .cfg_tgl(cfg_tgl), .cfg_run(cfg_run), .cfg_psc(cfg_psc),
      .cfg_cmp(cfg_cmp), .match_tgl(match_tgl), .eng_active(eng_active),
      .snap_req(snap_req), .snap_ack(snap_ack), .snap_val(snap_val),
      .int_flag(int_flag), .wake_flag(wake_flag), .irq(irq), .wake(wake)
   );

   lptmr_engine #(.CNT_W(CNT_W), .PSC_W(PSC_W), .SYNC_N(SYNC_N), .HAS_PSC(HAS_PSC)) u_eng (
      .clk(eng_clk), .rst_n(rst_n), .cfg_tgl(cfg_tgl), .cfg_run(cfg_run),
      .cfg_psc(cfg_psc), .cfg_cmp(cfg_cmp), .snap_req(snap_req),
      .match_tgl(match_tgl), .active(eng_active), .snap_ack(snap_ack),
      .snap_val(snap_val), .cnt_o(eng_cnt)
   );
endmodule

// File: rtl/lptmr_chk.sv
`timescale 1ns/1ps
module lptmr_chk #(
   parameter int CNT_W  = 24,
   parameter int PSC_W  = 7,
   parameter int SYNC_N = 2
) (
   input logic             bus_clk,
   input logic             eng_clk,
   input logic             rst_n,
   input logic             eng_active,
   input logic [CNT_W-1:0] eng_cnt,
   input logic             int_flag,
   input logic             wake_flag,
   input logic             irq
);
   initial begin
      assert (CNT_W >= 3 && CNT_W <= 31) else $error("CNT_W out of range");
      assert (PSC_W >= 1 && PSC_W <= 23) else $error("PSC_W out of range");
      assert (SYNC_N >= 2)               else $error("SYNC_N below 2");
   end

   assert_cnt_step_R1: assert property (@(posedge eng_clk) disable iff (!rst_n)
      (eng_active && $past(eng_active) && eng_cnt != $past(eng_cnt)) |->
      ((eng_cnt == $past(eng_cnt) + 1'b1) || ($past(eng_cnt) == '1 && eng_cnt == '0)));

   assert_start_zero_R5: assert property (@(posedge eng_clk) disable iff (!rst_n)
      $rose(eng_active) |-> (eng_cnt == '0));

   assert_stop_hold_R5: assert property (@(posedge eng_clk) disable iff (!rst_n)
      !eng_active |=> ($stable(eng_cnt) || (eng_active && eng_cnt == '0)));

   assert_flags_pair_R3: assert property (@(posedge bus_clk) disable iff (!rst_n)
      $rose(int_flag) |-> wake_flag);

   assert_irq_src_R11: assert property (@(posedge bus_clk) disable iff (!rst_n)
      irq |-> $past(int_flag));
endmodule

bind lptmr_top lptmr_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W), .SYNC_N(SYNC_N)) u_chk (
   .bus_clk(bus_clk), .eng_clk(eng_clk), .rst_n(rst_n), .eng_active(eng_active),
   .eng_cnt(eng_cnt), .int_flag(int_flag), .wake_flag(wake_flag), .irq(irq)
);

// File: tb/sim_lptmr_top.sv
`timescale 1ns/1ps
module sim_lptmr_top;
   localparam int CW   = 10;
   localparam int PW   = 7;
   localparam int MAXV = (1 << CW) - 1;
   localparam int PMAX = (1 << PW) - 1;

   logic        bus_clk = 1'b0;
   logic        eng_clk = 1'b0;
   logic        rst_n   = 1'b0;
   logic        wr_en   = 1'b0;
   logic [1:0]  addr    = 2'd0;
   logic [31:0] wdata   = '0;
   wire  [31:0] rdata;
   wire         irq, wake;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [31:0] rv;
   int c0, c1, ex, n, p;

   always #2    bus_clk = ~bus_clk;
   always #18.5 eng_clk = ~eng_clk;

   lptmr_top #(.CNT_W(CW)) u0 (
      .bus_clk(bus_clk), .eng_clk(eng_clk), .rst_n(rst_n), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wake(wake)
   );

   function automatic logic [31:0] cw(bit run, bit ie, bit we, bit rd, int psc);
      logic [31:0] r = '0;
      r[0] = run; r[1] = ie; r[2] = we; r[3] = rd;
      r[8 +: PW] = psc[PW-1:0];
      return r;
   endfunction

   function automatic int dlt(int a, int b);
      return (b - a) & MAXV;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_rng(string req, int act, int lo, int hi);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic bw(logic [1:0] a, logic [31:0] d);
      @(negedge bus_clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge bus_clk);
      wr_en = 1'b0;
   endtask

   task automatic br(logic [1:0] a, output logic [31:0] d);
      @(negedge bus_clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic ewait(int k);
      repeat (k) @(posedge eng_clk);
   endtask

   task automatic cfg(logic [1:0] a, logic [31:0] d);
      bw(a, d);
      ewait(6);
   endtask

   task automatic rcnt(output int v);
      logic [31:0] t;
      br(2'd3, t);
      v = int'(t);
   endtask

   initial begin
      #800000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (10) @(negedge bus_clk);
      rst_n = 1'b1;
      ewait(2);

      // reset state
      br(2'd0, rv); check("R9 reset ctrl", rv, 32'h0);
      br(2'd1, rv); check("R7 reset cmp", rv, 32'h0);
      br(2'd2, rv); check("R8 reset stat", rv, 32'h0);
      br(2'd3, rv); check("R10 reset cnt", rv, 32'h0);
      check("R11 reset irq", {31'b0, irq}, 32'h0);
      check("R11 reset wake", {31'b0, wake}, 32'h0);

      // R7 read-back of bus copy, R9 active only after the crossing
      bw(2'd0, cw(1, 0, 0, 1, 0));
      br(2'd0, rv); check("R7 R9 ctrl readback before active", rv, cw(1, 0, 0, 1, 0));
      ewait(6);
      br(2'd0, rv); check("R9 active set", {31'b0, rv[31]}, 32'h1);
      bw(2'd1, 32'hABCDE123);
      br(2'd1, rv); check("R7 cmp readback", rv, 32'hABCDE123 & MAXV);
      ewait(6);

      // R1 R2 rate, prescaler 0 then 3 while running
      rcnt(c0); ewait(100); rcnt(c1);
      check_rng("R1 rate psc0", dlt(c0, c1), 97, 104);
      cfg(2'd0, cw(1, 0, 0, 1, 3));
      br(2'd0, rv); check("R2 still active after psc change", {31'b0, rv[31]}, 32'h1);
      rcnt(c0); ewait(200); rcnt(c1);
      check_rng("R2 rate psc3", dlt(c0, c1), 47, 54);

      // R10 read enable off
      cfg(2'd0, cw(1, 0, 0, 0, 3));
      br(2'd3, rv); check("R10 cnt hidden", rv, 32'h0);

      // R3 continuous match, psc 1
      cfg(2'd0, cw(1, 0, 0, 1, 1));
      rcnt(c0);
      bw(2'd1, 32'((c0 + 40) & MAXV));
      ewait(6);
      bw(2'd2, 32'h3);
      br(2'd2, rv); check("R3 no flag before match", rv, 32'h0);
      ewait(120);
      br(2'd2, rv); check("R3 both flags on match", rv, 32'h3);
      rcnt(c1);
      check_rng("R3 counter continues past match", dlt(c0, c1), 50, 80);
      check("R11 irq masked", {31'b0, irq}, 32'h0);
      check("R11 wake masked", {31'b0, wake}, 32'h0);
      cfg(2'd0, cw(1, 1, 0, 1, 1));
      check("R11 irq enabled", {31'b0, irq}, 32'h1);
      check("R11 wake still masked", {31'b0, wake}, 32'h0);
      cfg(2'd0, cw(1, 1, 1, 1, 1));
      check("R11 wake enabled", {31'b0, wake}, 32'h1);
      bw(2'd2, 32'h1);
      br(2'd2, rv); check("R8 clear int only", rv, 32'h2);
      check("R8 R11 irq drops", {31'b0, irq}, 32'h0);
      check("R8 R11 wake stays", {31'b0, wake}, 32'h1);
      bw(2'd2, 32'h2);
      br(2'd2, rv); check("R8 clear wake", rv, 32'h0);
      br(2'd2, rv); check("R11 wake drops", {31'b0, wake}, 32'h0);

      // R4 rewrite compare while running
      rcnt(c0);
      bw(2'd1, 32'((c0 + 30) & MAXV));
      ewait(6);
      rcnt(c1);
      check_rng("R4 counter untouched by cmp write", dlt(c0, c1), 1, 10);
      br(2'd2, rv); check("R4 no early match", rv, 32'h0);
      ewait(80);
      br(2'd2, rv); check("R4 new match point hit", rv, 32'h3);
      bw(2'd2, 32'h3);
      br(2'd2, rv); check("R8 clear both at once", rv, 32'h0);

      // R5 stop holds, restart from zero
      cfg(2'd0, cw(0, 1, 1, 1, 0));
      br(2'd0, rv); check("R9 active clears on stop", {31'b0, rv[31]}, 32'h0);
      rcnt(c0); ewait(20); rcnt(c1);
      check("R5 held while stopped", 32'(c1), 32'(c0));
      cfg(2'd1, 32'd200);
      cfg(2'd0, cw(1, 1, 1, 1, 0));
      rcnt(c1);
      check_rng("R5 restart from zero", c1, 0, 9);

      // R6 clamp of small compare values
      cfg(2'd0, cw(0, 0, 0, 1, 0));
      cfg(2'd1, 32'd0);
      bw(2'd2, 32'h3);
      cfg(2'd0, cw(1, 0, 0, 1, 0));
      ewait(20);
      br(2'd2, rv); check("R6 cmp 0 acts as 2", rv, 32'h3);
      cfg(2'd0, cw(0, 0, 0, 1, PMAX));
      cfg(2'd1, 32'd1);
      bw(2'd2, 32'h3);
      cfg(2'd0, cw(1, 0, 0, 1, PMAX));
      ewait(190);
      rcnt(c1); check("R6 R2 count 1 at max prescale", 32'(c1), 32'd1);
      br(2'd2, rv); check("R6 no match at 1", rv, 32'h0);
      ewait(150);
      br(2'd2, rv); check("R6 match at 2", rv, 32'h3);

      // R1 wrap
      cfg(2'd0, cw(1, 0, 0, 1, 0));
      cfg(2'd1, 32'd20);
      rcnt(c0);
      for (int i = 0; i < 200 && c0 < 900; i++) begin
         ewait(8);
         rcnt(c0);
      end
      bw(2'd2, 32'h3);
      rcnt(c0);
      ewait(200);
      rcnt(c1);
      check_rng("R1 wrap to zero", c1, 60, 130);
      br(2'd2, rv); check("R1 R3 match after wrap", rv, 32'h3);

      // R2 random prescale and window
      for (int t = 0; t < 6; t++) begin
         p = int'($urandom % 4);
         n = 40 + int'($urandom % 160);
         cfg(2'd0, cw(1, 0, 0, 1, p));
         rcnt(c0); ewait(n); rcnt(c1);
         ex = n / (p + 1);
         check_rng("R2 random rate", dlt(c0, c1), ex - 3, ex + 4);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule